// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Generator

This block is the divider chain behind a real-time clock's periodic event logic. It counts pulses of a reference-enable strobe through a chain of binary stages. From that chain it derives three results: a sticky periodic event flag, a gated square-wave pin, and a one-cycle tick once per second that the time-keeping core consumes. A 3-bit chain-control field either lets the chain run, holds it in its reset state, or freezes it. A 4-bit rate code picks which binary stage drives the flag and the square wave.

The strobe `ref_en` is expected once per half-period of a 32.768 kHz reference, so 65536 strobes make one second. Rate code n (1..15) selects stage n-1, whose frequency is 32768 / 2^(n-1) Hz: code 1 gives about 32.8 kHz and code 15 gives 2 Hz. Only the 32.768 kHz chain-control selection is modelled as running. The host reads the flag through the shared register decode and clears it with `flag_clear`.

Top module: `rtc_periodic_gen`

## Requirements
- R1: The chain advances by one step on each clock with `ref_en` high while `div_ctl` is 3'b010. With `ref_en` low, or with `div_ctl` at any code other than 3'b010, 3'b110 or 3'b111, it holds still, and `sq_wave` and `periodic_flag` keep their values.
- R2: `div_ctl` of 3'b110 or 3'b111 holds the chain in its reset state. In that state every rate stage is low, `sq_wave` is 0 and no new flag is set.
- R3: With rate code n in 1..15, the selected stage stays high for 2^(n-1) steps and then low for 2^(n-1) steps, which is a 50 % duty cycle.
- R4: `sq_wave` follows the selected stage only when `sqw_en` is 1 and the rate code is nonzero. Otherwise it is 0.
- R5: `periodic_flag` is set in the same clock as each low-to-high transition of the selected stage, whatever the value of `pie_en`. Rate code 0 never sets it. After the chain leaves reset, the first set comes 2^(n-1) steps later.
- R6: `flag_clear` clears `periodic_flag` on the next edge. A set in that same cycle takes priority.
- R7: `irq` is high exactly when `periodic_flag` and `pie_en` are both 1.
- R8: `sec_tick` is a one-cycle pulse every 65536 steps. The first pulse comes 32768 steps after the chain leaves reset, which is half a second.
- R9: After `rst`, `periodic_flag`, `irq`, `sq_wave` and `sec_tick` are 0, and the chain is in its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference strobe, one per reference half-period |
| div_ctl | input | 3 | Chain control: 010 runs, 110/111 reset, others freeze |
| rate_sel | input | 4 | Rate code, 0 = off, n selects stage n-1 |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| flag_clear | input | 1 | Clears the periodic flag (flag register read) |
| periodic_flag | output | 1 | Sticky periodic event flag |
| irq | output | 1 | Periodic interrupt request |
| sq_wave | output | 1 | Square-wave output |
| sec_tick | output | 1 | One-cycle pulse once per second |

## Verification
The chain counter, the flag and the seconds tick all update on the same clock edge as the step that causes them. `irq` and `sq_wave` are combinational from registered state. So every result is due one edge after the strobe or control change that produces it. The bench drives inputs on the falling edge and samples on the next falling edge. After the chain leaves reset it counts edges exactly, so it can expect the first flag at edge 2^(n-1), the first tick at edge 32768 and the next one 65536 edges later.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    localparam int CHAIN_W = 16;
    localparam int RATE_W  = 4;
    localparam int CTL_W   = 3;

    localparam logic [CTL_W-1:0] CTL_RUN_32K = 3'b010;
    localparam logic [CTL_W-1:0] CTL_RST_A   = 3'b110;
    localparam logic [CTL_W-1:0] CTL_RST_B   = 3'b111;

    typedef enum logic [1:0] {
        CHAIN_RUN,
        CHAIN_HOLD,
        CHAIN_CLEAR
    } chain_mode_e;

    typedef struct packed {
        logic level;
        logic rise;
    } tap_t;

    function automatic chain_mode_e decode_mode(input logic [CTL_W-1:0] ctl);
        if (ctl == CTL_RST_A || ctl == CTL_RST_B) return CHAIN_CLEAR;
        if (ctl == CTL_RUN_32K) return CHAIN_RUN;
        return CHAIN_HOLD;
    endfunction

endpackage

// File: rtl/rpg_chain.sv
module rpg_chain
    import rpg_pkg::*;
#(
    parameter int W = CHAIN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_en,
    input  chain_mode_e  mode,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         step,
    output logic         sec_tick
);
    localparam logic [W-1:0] PRESET = W'(1) << (W - 1);

    always_comb begin
        step  = (mode == CHAIN_RUN) && ref_en;
        cnt_d = cnt_q;
        if (mode == CHAIN_CLEAR) cnt_d = PRESET;
        else if (step)           cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= PRESET;
            sec_tick <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            sec_tick <= step && (&cnt_q);
        end
    end

    p_div_reset_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == CHAIN_CLEAR) |=> (cnt_q == PRESET));

    p_frozen_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == CHAIN_HOLD || !ref_en) && (mode != CHAIN_CLEAR) |=> $stable(cnt_q));

    p_tick_single_r8: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

endmodule

// File: rtl/rpg_tap.sv
module rpg_tap
    import rpg_pkg::*;
#(
    parameter int W  = CHAIN_W,
    parameter int RW = RATE_W
) (
    input  logic [W-1:0]  cnt_q,
    input  logic [W-1:0]  cnt_d,
    input  logic [RW-1:0] rate,
    output tap_t          tap
);
    localparam int NTAPS = (1 << RW) - 1;

    logic [NTAPS:0] lvl_vec;
    logic [NTAPS:0] rise_vec;

    assign lvl_vec[0]  = 1'b0;
    assign rise_vec[0] = 1'b0;

    generate
        for (genvar n = 1; n <= NTAPS; n++) begin : g_tap
            if (n - 1 < W) begin : g_live
                assign lvl_vec[n]  = cnt_q[n-1];
                assign rise_vec[n] = !cnt_q[n-1] && cnt_d[n-1];
            end else begin : g_dead
                assign lvl_vec[n]  = 1'b0;
                assign rise_vec[n] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        tap.level = lvl_vec[rate];
        tap.rise  = rise_vec[rate];
    end

endmodule

// File: rtl/rpg_flag.sv
module rpg_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr_i && !set_i |=> !flag_q);

endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
    import rpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic [CTL_W-1:0]  div_ctl,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              pie_en,
    input  logic              sqw_en,
    input  logic              flag_clear,
    output logic              periodic_flag,
    output logic              irq,
    output logic              sq_wave,
    output logic              sec_tick
);
    chain_mode_e        mode;
    logic [CHAIN_W-1:0] cnt_q;
    logic [CHAIN_W-1:0] cnt_d;
    logic               step;
    tap_t               tap;
    logic               rate_on;

    assign mode    = decode_mode(div_ctl);
    assign rate_on = (rate_sel != '0);

    rpg_chain #(.W(CHAIN_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .ref_en   (ref_en),
        .mode     (mode),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .step     (step),
        .sec_tick (sec_tick)
    );

    rpg_tap #(.W(CHAIN_W), .RW(RATE_W)) u_tap (
        .cnt_q (cnt_q),
        .cnt_d (cnt_d),
        .rate  (rate_sel),
        .tap   (tap)
    );

    rpg_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (tap.rise && rate_on),
        .clr_i  (flag_clear),
        .flag_q (periodic_flag)
    );

    assign irq     = periodic_flag && pie_en;
    assign sq_wave = sqw_en && rate_on && tap.level;

    p_sqw_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!sqw_en || !rate_on) |-> !sq_wave);

    p_rate_off_r5: assert property (@(posedge clk) disable iff (rst)
        !rate_on && !periodic_flag |=> !periodic_flag);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> periodic_flag);

    p_no_tick_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == CHAIN_CLEAR) |=> !sec_tick);

endmodule

// File: tb/rtc_periodic_gen_test.sv
module rtc_periodic_gen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b1;
    logic [2:0] div_ctl = 3'b110;
    logic [3:0] rate_sel = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       flag_clear = 1'b0;
    logic       periodic_flag, irq, sq_wave, sec_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_periodic_gen uut (
        .clk(clk), .rst(rst), .ref_en(ref_en), .div_ctl(div_ctl),
        .rate_sel(rate_sel), .pie_en(pie_en), .sqw_en(sqw_en),
        .flag_clear(flag_clear), .periodic_flag(periodic_flag), .irq(irq),
        .sq_wave(sq_wave), .sec_tick(sec_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // hold chain in reset, clear flag, then release at a falling edge
    task automatic restart(input logic [3:0] rate);
        div_ctl = 3'b110; rate_sel = rate; ref_en = 1'b1;
        flag_clear = 1'b1; edges(1);
        flag_clear = 1'b0; edges(1);
        div_ctl = 3'b010;
    endtask

    task automatic t_reset;
        check(periodic_flag == 0, "R9 flag", periodic_flag, 0);
        check(irq == 0, "R9 irq", irq, 0);
        check(sq_wave == 0, "R9 sq_wave", sq_wave, 0);
        check(sec_tick == 0, "R9 sec_tick", sec_tick, 0);
    endtask

    task automatic t_square;
        int highs = 0, rises = 0;
        logic prev;
        sqw_en = 1'b1;
        restart(4'd3);
        edges(1);
        prev = sq_wave;
        if (sq_wave) highs++;
        for (int i = 1; i < 64; i++) begin
            edges(1);
            if (sq_wave) highs++;
            if (sq_wave && !prev) rises++;
            prev = sq_wave;
        end
        check(highs == 32, "R3 duty", highs, 32);
        check(rises == 8, "R3 period", rises, 8);
    endtask

    task automatic t_flag_timing;
        pie_en = 1'b0; sqw_en = 1'b0;
        restart(4'd4);
        edges(7);
        check(periodic_flag == 0, "R5 early", periodic_flag, 0);
        edges(1);
        check(periodic_flag == 1, "R5 set at 8", periodic_flag, 1);
        check(irq == 0, "R7 masked", irq, 0);
        pie_en = 1'b1; edges(1);
        check(irq == 1, "R7 enabled", irq, 1);
        pie_en = 1'b0; edges(1);
        check(irq == 0, "R7 disabled", irq, 0);
    endtask

    task automatic t_clear_collision;
        restart(4'd1);
        flag_clear = 1'b1;
        edges(1);
        flag_clear = 1'b0;
        check(periodic_flag == 1, "R6 set wins", periodic_flag, 1);
        flag_clear = 1'b1;
        edges(1);
        flag_clear = 1'b0;
        check(periodic_flag == 0, "R6 clear", periodic_flag, 0);
    endtask

    task automatic t_rate_zero;
        int bad_f = 0, bad_s = 0;
        sqw_en = 1'b1;
        restart(4'd0);
        for (int i = 0; i < 64; i++) begin
            edges(1);
            if (periodic_flag) bad_f++;
            if (sq_wave) bad_s++;
        end
        check(bad_f == 0, "R5 rate0 no flag", bad_f, 0);
        check(bad_s == 0, "R4 rate0 low", bad_s, 0);
    endtask

    task automatic t_sqw_disabled;
        int bad_s = 0;
        sqw_en = 1'b0;
        restart(4'd3);
        for (int i = 0; i < 32; i++) begin
            edges(1);
            if (sq_wave) bad_s++;
        end
        check(bad_s == 0, "R4 disabled low", bad_s, 0);
        check(periodic_flag == 1, "R5 flag without enables", periodic_flag, 1);
    endtask

    task automatic freeze_run(input string req);
        int bad = 0;
        flag_clear = 1'b1; edges(1);
        flag_clear = 1'b0;
        for (int i = 0; i < 20; i++) begin
            edges(1);
            if (sq_wave != 1'b1 || periodic_flag) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_freeze;
        sqw_en = 1'b1;
        restart(4'd2);
        edges(2);
        check(sq_wave == 1, "R3 stage up after 2", sq_wave, 1);
        div_ctl = 3'b000;
        freeze_run("R1 frozen by code 000");
        div_ctl = 3'b010; ref_en = 1'b0;
        freeze_run("R1 frozen by ref_en low");
        ref_en = 1'b1; div_ctl = 3'b111;
        edges(1);
        flag_clear = 1'b1; edges(1);
        flag_clear = 1'b0;
        edges(10);
        check(sq_wave == 0, "R2 reset stage low", sq_wave, 0);
        check(periodic_flag == 0, "R2 no flag in reset", periodic_flag, 0);
    endtask

    task automatic t_second;
        int first_flag = -1, tick1 = -1, tick2 = -1, pulses = 0;
        sqw_en = 1'b0;
        restart(4'd15);
        for (int i = 1; i <= 98304; i++) begin
            edges(1);
            if (periodic_flag && first_flag < 0) first_flag = i;
            if (sec_tick) begin
                pulses++;
                if (tick1 < 0) tick1 = i;
                else if (tick2 < 0) tick2 = i;
            end
        end
        check(first_flag == 16384, "R5 rate15 first flag", first_flag, 16384);
        check(tick1 == 32768, "R8 first tick", tick1, 32768);
        check(tick2 == 98304, "R8 second tick", tick2, 98304);
        check(pulses == 2, "R8 pulse width", pulses, 2);
    endtask

    initial begin
        edges(3);
        t_reset();
        rst = 1'b0;
        t_square();
        t_flag_timing();
        t_clear_collision();
        t_rate_zero();
        t_sqw_disabled();
        t_freeze();
        t_second();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule